// File: doc/BRIEF.md
# Branch Clock Gate with Running Status

This block gates one source clock under register control and tells software, through a read-only status field, whether the gated clock is really running. Two requesters can turn the branch on. The first is a local enable bit in the branch's own control word. The second is this branch's bit in a shared vote word, which several branches can decode at once. The effective request is the OR of the two.

The request is made in the register clock domain. It is synchronized into the source clock domain and drives a latch-based gate that only changes while the source clock is low. The gate's actual state is captured in the source domain and synchronized back to the register domain. The status field therefore moves from off to on, or from on to off, only after the gate has really switched. Software writes the enable, then polls the status until it shows an on code.

Top module: `branch_clk_gate`

## Requirements
- R1: After reset the control word (address 0) reads 0x8000_0000, the vote word (address 1) reads 0, and `clk_out` does not toggle.
- R2: Bit 0 of the control word is a read/write local enable that reads back the last value written to it.
- R3: The vote word is VOTE_W bits wide and fully read/write. Only its bit VOTE_IDX (default 3) requests this branch. Setting any other vote bit alone leaves the branch off.
- R4: `clk_out` follows `clk_src` while the branch is on and stays low while it is off. The gate state changes only while `clk_src` is low, so no shortened pulse appears.
- R5: Control bit 31 is a read-only clock-off flag. After a request it stays 1 for at least two register clock cycles. It clears within 16 register cycles while `clk_src` toggles.
- R6: Control bits 31:28 form the status code, with three legal values. 4'b1000 means off. 4'b0000 means on with the local enable set. 4'b0010 means on through the vote bit alone, and it also counts as an on state.
- R7: Writes to control bits 31:1 are ignored. Bits 27:1 always read 0.
- R8: When the effective request drops, bit 31 returns to 1 within 16 register cycles, and `clk_out` stops toggling.
- R9: Addresses 2 and 3 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Register port clock |
| clk_src | input | 1 | Source clock to be gated |
| rst_n | input | 1 | Asynchronous active-low reset; each domain releases it synchronously |
| reg_wr | input | 1 | Write strobe, sampled on `clk_reg` |
| reg_addr | input | ADDR_W (2) | Word address: 0 control, 1 vote |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| clk_out | output | 1 | Gated clock |

## Verification
The assertions check four things on every edge. Local-enable and vote writes land as written. The status field never shows a code outside the three legal ones, and it never shows the vote-only code while the local enable is set. The latch output, sampled at each rising source edge, equals the synchronized request from the preceding low phase. Several properties depend on the two clocks interacting and can only be shown by the bench's scenarios. These are the minimum and maximum latency of the off flag in both directions, the ability of a vote bit to turn the branch on and of a foreign vote bit to leave it off, and the actual presence or absence of `clk_out` edges.

// File: rtl/bcg_pkg.sv
`timescale 1ns/1ps
package bcg_pkg;

  localparam logic [3:0] ST_OFF       = 4'b1000;
  localparam logic [3:0] ST_ON_LOCAL  = 4'b0000;
  localparam logic [3:0] ST_ON_VOTED  = 4'b0010;

  localparam int unsigned STATUS_W = 4;

  // Status code from the reported running state and the local enable.
  function automatic logic [3:0] status_code(input logic running, input logic local_en);
    if (!running)      return ST_OFF;
    else if (local_en) return ST_ON_LOCAL;
    else               return ST_ON_VOTED;
  endfunction

endpackage

// File: rtl/bcg_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchronizer with asynchronous clear. With d tied
// high it serves as a reset synchronizer (async assert, sync release).
module bcg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/bcg_gate.sv
`timescale 1ns/1ps
// Source-domain part: request synchronizer, low-phase latch gate and
// captured gate state for the return path.
module bcg_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_src_n,
  input  logic en_req,
  output logic clk_out,
  output logic gate_on
);

  logic en_sync;
  logic en_lat;
  logic gate_on_q;
  logic gate_on_d;

  bcg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (clk_src),
    .rst_n (rst_src_n),
    .d     (en_req),
    .q     (en_sync)
  );

  // Transparent while the source clock is low; holds during the high phase.
  always_latch begin
    if (!rst_src_n)    en_lat = 1'b0;
    else if (!clk_src) en_lat = en_sync;
  end

  assign clk_out = clk_src & en_lat;

  // Capture what the gate actually holds for the return synchronizer.
  always_comb gate_on_d = en_lat;

  always_ff @(posedge clk_src or negedge rst_src_n) begin
    if (!rst_src_n) gate_on_q <= 1'b0;
    else            gate_on_q <= gate_on_d;
  end

  assign gate_on = gate_on_q;

  // R4: at each rising edge the latch holds what the synchronizer drove
  // during the preceding low phase.
  assert_gate_tracks_R4: assert property (@(posedge clk_src) disable iff (!rst_src_n)
    en_lat == en_sync);

endmodule

// File: rtl/bcg_regs.sv
`timescale 1ns/1ps
// Register-domain part: control and vote words, read mux, request OR.
module bcg_regs
  import bcg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned VOTE_W   = 8,
  parameter int unsigned VOTE_IDX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clk_on,
  output logic [DATA_W-1:0] rdata,
  output logic              en_req
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] VOTE_ADDR = ADDR_W'(1);
  localparam int unsigned       ST_LSB    = DATA_W - STATUS_W;
  localparam int unsigned       GAP_W     = ST_LSB - 1;

  logic              ctl_en_q, ctl_en_d, ctl_en_we;
  logic [VOTE_W-1:0] vote_q,   vote_d,   vote_we_data;
  logic              vote_we;
  logic [3:0]        status;
  logic              unused_wdata;

  // Next-state logic with explicit write enables.
  always_comb begin
    ctl_en_we    = wr && (addr == CTRL_ADDR);
    vote_we      = wr && (addr == VOTE_ADDR);
    vote_we_data = wdata[VOTE_W-1:0];
    ctl_en_d     = ctl_en_we ? wdata[0] : ctl_en_q;
    vote_d       = vote_we ? vote_we_data : vote_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en_q <= 1'b0;
      vote_q   <= '0;
    end else begin
      ctl_en_q <= ctl_en_d;
      vote_q   <= vote_d;
    end
  end

  assign unused_wdata = ^wdata[DATA_W-1:VOTE_W];
  assign en_req       = ctl_en_q | vote_q[VOTE_IDX];
  assign status       = status_code(clk_on, ctl_en_q);

  always_comb begin
    unique case (addr)
      CTRL_ADDR: rdata = {status, {GAP_W{1'b0}}, ctl_en_q};
      VOTE_ADDR: rdata = DATA_W'(vote_q);
      default:   rdata = '0;
    endcase
  end

  // R2: a control write lands the local enable exactly as written.
  assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == CTRL_ADDR) |=> (ctl_en_q == $past(wdata[0])));

  // R3: a vote write lands the whole vote word.
  assert_vote_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == VOTE_ADDR) |=> (vote_q == $past(wdata[VOTE_W-1:0])));

  // R6: only the three legal codes appear in the status field.
  assert_status_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == CTRL_ADDR) |->
      (rdata[DATA_W-1 -: 4] == ST_OFF || rdata[DATA_W-1 -: 4] == ST_ON_LOCAL ||
       rdata[DATA_W-1 -: 4] == ST_ON_VOTED));

  // R6: the vote-only code never appears while the local enable reads 1.
  assert_voted_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == CTRL_ADDR && rdata[0]) |-> (rdata[DATA_W-1 -: 4] != ST_ON_VOTED));

endmodule

// File: rtl/branch_clk_gate.sv
`timescale 1ns/1ps
module branch_clk_gate #(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned VOTE_W      = 8,
  parameter int unsigned VOTE_IDX    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_reg,
  input  logic              clk_src,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              clk_out
);

  logic rst_reg_n;
  logic rst_src_n;
  logic en_req;
  logic gate_on;
  logic clk_on;

  bcg_sync #(.STAGES(SYNC_STAGES)) u_rst_reg (
    .clk (clk_reg), .rst_n (rst_n), .d (1'b1), .q (rst_reg_n)
  );

  bcg_sync #(.STAGES(SYNC_STAGES)) u_rst_src (
    .clk (clk_src), .rst_n (rst_n), .d (1'b1), .q (rst_src_n)
  );

  bcg_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .VOTE_W   (VOTE_W),
    .VOTE_IDX (VOTE_IDX)
  ) u_regs (
    .clk    (clk_reg),
    .rst_n  (rst_reg_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .clk_on (clk_on),
    .rdata  (reg_rdata),
    .en_req (en_req)
  );

  bcg_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk_src   (clk_src),
    .rst_src_n (rst_src_n),
    .en_req    (en_req),
    .clk_out   (clk_out),
    .gate_on   (gate_on)
  );

  // Return path: real gate state back into the register domain.
  bcg_sync #(.STAGES(SYNC_STAGES)) u_on_sync (
    .clk (clk_reg), .rst_n (rst_reg_n), .d (gate_on), .q (clk_on)
  );

endmodule

// File: tb/branch_clk_gate_bench.sv
`timescale 1ns/1ps
module branch_clk_gate_bench;

  localparam int unsigned VOTE_W   = 8;
  localparam int unsigned VOTE_IDX = 3;
  localparam int          LAT_MAX  = 16;

  logic        clk_reg = 1'b0;
  logic        clk_src = 1'b0;
  logic        rst_n   = 1'b0;
  logic        reg_wr  = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        clk_out;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  bit done   = 1'b0;

  always #4 clk_reg = ~clk_reg;   // 125 MHz
  always #3 clk_src = ~clk_src;

  always @(posedge clk_out) edges++;

  branch_clk_gate u_branch_clk_gate (
    .clk_reg   (clk_reg),
    .clk_src   (clk_src),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .clk_out   (clk_out)
  );

  function automatic logic [31:0] exp_ctrl(input logic en, input logic [VOTE_W-1:0] vote);
    logic on;
    logic [3:0] st;
    on = en | vote[VOTE_IDX];
    st = !on ? 4'b1000 : (en ? 4'b0000 : 4'b0010);
    return {st, 27'b0, en};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_reg);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk_reg);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_reg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_reg);
  endtask

  // Poll control until bit 31 equals want; returns cycles taken (or -1).
  task automatic poll_off(input logic want, output int cyc);
    logic [31:0] v;
    cyc = -1;
    for (int i = 0; i <= LAT_MAX; i++) begin
      rd(2'd0, v);
      if (v[31] == want) begin cyc = i; break; end
      @(negedge clk_reg);
    end
  endtask

  task automatic edge_window(input int n, output int cnt);
    int e0;
    e0 = edges;
    wait_reg(n);
    cnt = edges - e0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cyc, cnt;
    void'($urandom(32'd1234));

    wait_reg(4);
    rst_n = 1'b1;
    wait_reg(4);

    // R1: reset state
    rd(2'd0, v); chk("R1 ctrl reset", v, 32'h8000_0000);
    rd(2'd1, v); chk("R1 vote reset", v, 32'h0);
    edge_window(10, cnt); chk("R1 no clock after reset", cnt, 0);

    // R7: status write ignored while off, gap bits read zero
    wr(2'd0, 32'hFFFF_FFFE);
    rd(2'd0, v); chk("R7 ro bits ignored", v, 32'h8000_0000);

    // R2/R5: local enable, minimum latency then bounded turn-on
    wr(2'd0, 32'h7000_0001);
    rd(2'd0, v); chk("R5 off flag still set right after request", v, 32'h8000_0001);
    @(negedge clk_reg);
    rd(2'd0, v); chk("R5 off flag set two cycles after request", {31'b0, v[31]}, 32'd1);
    poll_off(1'b0, cyc);
    chk("R5 turn-on within bound", {31'b0, cyc >= 0}, 32'd1);
    rd(2'd0, v); chk("R2 R6 on local code", v, 32'h0000_0001);
    edge_window(10, cnt); chk("R4 clock runs when on", {31'b0, cnt > 0}, 32'd1);

    // R8: turn off
    wr(2'd0, 32'h0);
    poll_off(1'b1, cyc);
    chk("R8 turn-off within bound", {31'b0, cyc >= 0}, 32'd1);
    wait_reg(4);
    edge_window(10, cnt); chk("R8 clock stopped", cnt, 0);

    // R3: foreign vote bit has no effect, own bit turns on
    wr(2'd1, 32'hF7);
    wait_reg(LAT_MAX);
    rd(2'd0, v); chk("R3 foreign vote bits stay off", v, 32'h8000_0000);
    rd(2'd1, v); chk("R3 vote readback", v, 32'h0000_00F7);
    edge_window(10, cnt); chk("R3 no clock on foreign vote", cnt, 0);
    wr(2'd1, 32'h08);
    poll_off(1'b0, cyc);
    chk("R3 vote turn-on within bound", {31'b0, cyc >= 0}, 32'd1);
    rd(2'd0, v); chk("R6 on voted code", v, 32'h2000_0000);
    wr(2'd0, 32'h1);
    wait_reg(2);
    rd(2'd0, v); chk("R6 local plus vote code", v, 32'h0000_0001);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    poll_off(1'b1, cyc);
    chk("R8 vote removal turns off", {31'b0, cyc >= 0}, 32'd1);

    // R9: unmapped addresses
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R9 addr2 reads zero", v, 32'h0);
    rd(2'd3, v); chk("R9 addr3 reads zero", v, 32'h0);
    rd(2'd1, v); chk("R9 vote untouched", v, 32'h0);
    wait_reg(LAT_MAX);
    rd(2'd0, v); chk("R9 ctrl untouched", v, 32'h8000_0000);

    // Random mix of local enable and vote words
    for (int it = 0; it < 40; it++) begin
      logic en;
      logic [VOTE_W-1:0] vt;
      en = 1'($urandom);
      vt = VOTE_W'($urandom);
      wr(2'd0, {$urandom} & 32'hFFFF_FFFE | {31'b0, en});
      wr(2'd1, {24'b0, vt});
      wait_reg(LAT_MAX + 2);
      rd(2'd0, v); chk("R6 random ctrl", v, exp_ctrl(en, vt));
      rd(2'd1, v); chk("R3 random vote", v, {24'b0, vt});
      edge_window(8, cnt);
      chk("R4 random clock presence", {31'b0, cnt > 0}, {31'b0, en | vt[VOTE_IDX]});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule